// File: doc/BRIEF.md
# Chainable Serial Command and Fault Shifter

This block is the serial slave of an eight-channel output controller. It works off a system clock and takes the serial pins in through synchronizers. The chip-select line is active high. While the select is asserted, the block sends out an 8-bit snapshot of latched channel faults. In the same bits it takes in an 8-bit on/off command. Once the snapshot has gone out, the output carries the input bits delayed by eight serial clocks. Several devices can therefore share one select line and be wired in a chain.

A transaction counts only when its bit count is a nonzero multiple of eight and the serial clock is low at the moment the select falls. When a transaction counts, the last eight bits received become the command and the fault latch is cleared. Otherwise both stay as they were. Two of the channel enables are also forced on by discrete inputs, so those channels can be driven by pulse-width modulation without serial traffic.

The control path is a two-state machine with these states and transitions:
- `ST_IDLE`: the data output is disabled.
- `ST_IDLE` to `ST_SHIFT`: taken on a filtered rise of the select. This transition loads the fault snapshot and enables the output.
- `ST_SHIFT`: serial clock edges shift data in and out.
- `ST_SHIFT` to `ST_IDLE`: taken on a filtered fall of the select. This transition disables the output. If the transaction counts, it also commits the command and clears the faults.

Top module: `spi_cmd_fault_shifter`

## Requirements
- R1: After reset, `chan_en` is all zero, `sdo_oe` is low and the fault latch holds zero, so the first read returns 8'h00.
- R2: `sdo_oe` is high exactly while the filtered select is asserted (state `ST_SHIFT`) and low otherwise.
- R3: The first eight bits seen on `sdo` are the fault snapshot taken at the select rise, bit 7 first. `sdo` advances on falling `sclk` edges. `sdi` is sampled on rising `sclk` edges.
- R4: From the ninth bit on, `sdo` carries the `sdi` bit that was sampled eight rising edges earlier.
- R5: A transaction of 8·k bits (k ≥ 1) that ends with `sclk` low loads the command from the last eight `sdi` bits and clears the fault latch. The first of those eight bits goes to command bit 7. Command bit i enables channel i+1, and 1 means on.
- R6: A transaction whose bit count is not a multiple of eight, or that ends with `sclk` high, leaves both the command and the fault latch unchanged.
- R7: `chan_en[4]` is the command bit 4 OR `ext_en5`. `chan_en[5]` is the command bit 5 OR `ext_en6`. The other bits equal the command.
- R8: A change of `cs` lasting fewer than `FILT_CYC` system clocks (after synchronization) starts no transaction and changes no state.
- R9: A high bit on `fault_in` sets the matching latch bit, and the bit stays set until a clear. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Serial select, active high, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| fault_in | input | 8 | Per-channel fault set pulses |
| ext_en5 | input | 1 | Discrete enable ORed into channel 5 |
| ext_en6 | input | 1 | Discrete enable ORed into channel 6 |
| sdo | output | 1 | Serial data out (valid when `sdo_oe` is high) |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high-impedance |
| chan_en | output | 8 | Channel enables |

## Verification
The latch clear that a counted transaction performs can land in the same system cycle as a new fault set. The bench provokes this by holding one `fault_in` bit high through the whole fall of the select in a valid transaction. It then judges the result by reading the latch back in the next transaction: the held bit must still be 1 while the others read 0. An exhaustive sweep over all 256 command values, each paired with a distinct fault pattern, checks the snapshot, the commit and the clear against arithmetic expectations.

// File: rtl/spi_shf_pkg.sv
package spi_shf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shf_state_e;
endpackage

// File: rtl/spi_shf_sync.sv
module spi_shf_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_shf_csfilt.sv
module spi_shf_csfilt #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the filtered level only flips after a full run of disagreement
    assert_filt_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(cnt) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/spi_cmd_fault_shifter.sv
module spi_cmd_fault_shifter
    import spi_shf_pkg::*;
#(
    parameter int CH_W     = 8,
    parameter int FILT_CYC = 10,
    parameter int EXT_A    = 4,
    parameter int EXT_B    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            sclk,
    input  logic            sdi,
    input  logic [CH_W-1:0] fault_in,
    input  logic            ext_en5,
    input  logic            ext_en6,
    output logic            sdo,
    output logic            sdo_oe,
    output logic [CH_W-1:0] chan_en
);
    localparam int CNT_W = $clog2(CH_W);

    logic [2:0]       pins_s;
    logic             cs_s, sclk_s, sdi_s;
    logic             cs_f, cs_f_d, sclk_d;
    logic             sel_rise, sel_fall, clk_rise, clk_fall;

    shf_state_e       state, state_nx;
    logic             load_tx, end_xfer, commit_ok, shift_in, shift_out;

    logic [CH_W-1:0]  rx_sr, tx_sr, cmd_q, fault_q, ext_mask;
    logic [CNT_W-1:0] bit_cnt;
    logic             byte_seen, cap_bit, oe_q;

    spi_shf_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs, sclk, sdi}),
        .q    (pins_s)
    );
    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    spi_shf_csfilt #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (cs_s),
        .filt (cs_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_f_d <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            cs_f_d <= cs_f;
            sclk_d <= sclk_s;
        end
    end

    assign sel_rise = cs_f & ~cs_f_d;
    assign sel_fall = ~cs_f & cs_f_d;
    assign clk_rise = sclk_s & ~sclk_d;
    assign clk_fall = ~sclk_s & sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and control outputs
    always_comb begin
        state_nx  = state;
        load_tx   = 1'b0;
        end_xfer  = 1'b0;
        shift_in  = 1'b0;
        shift_out = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sel_rise) begin
                    load_tx  = 1'b1;
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sel_fall) begin
                    end_xfer = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    shift_in  = clk_rise;
                    shift_out = clk_fall;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign commit_ok = end_xfer && (bit_cnt == '0) && byte_seen && !sclk_s;

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr     <= '0;
            tx_sr     <= '0;
            cap_bit   <= 1'b0;
            bit_cnt   <= '0;
            byte_seen <= 1'b0;
            oe_q      <= 1'b0;
            cmd_q     <= '0;
        end else begin
            if (load_tx) begin
                tx_sr     <= fault_q;
                bit_cnt   <= '0;
                byte_seen <= 1'b0;
                oe_q      <= 1'b1;
            end
            if (shift_in) begin
                rx_sr   <= {rx_sr[CH_W-2:0], sdi_s};
                cap_bit <= sdi_s;
                if (bit_cnt == CNT_W'(CH_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_seen <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (shift_out) tx_sr <= {tx_sr[CH_W-2:0], cap_bit};
            if (end_xfer)  oe_q  <= 1'b0;
            if (commit_ok) cmd_q <= rx_sr;
        end
    end

    // fault latch: a set in the clearing cycle survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (commit_ok ? '0 : fault_q) | fault_in;
    end

    always_comb begin
        ext_mask        = '0;
        ext_mask[EXT_A] = ext_en5;
        ext_mask[EXT_B] = ext_en6;
    end

    assign chan_en = cmd_q | ext_mask;
    assign sdo     = tx_sr[CH_W-1];
    assign sdo_oe  = oe_q;

    // R2: output enable is never left on outside a transaction
    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load_tx) |=> !sdo_oe);

    // R5 / R6: the command only moves in a committing cycle
    assert_cmd_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != $past(cmd_q)) |-> $past(commit_ok));

    // R9: every set request is visible in the latch one cycle later
    assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_in) |=> ((fault_q & $past(fault_in)) == $past(fault_in)));

    // R7: discrete enables force their channels on
    assert_ext_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en5 && ext_en6) |-> (chan_en[EXT_A] && chan_en[EXT_B]));
endmodule

// File: tb/spi_cmd_fault_shifter_tb.sv
module spi_cmd_fault_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [7:0] fault_in = '0;
    logic       ext_en5 = 1'b0, ext_en6 = 1'b0;
    logic       sdo, sdo_oe;
    logic [7:0] chan_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_cmd_fault_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .fault_in(fault_in), .ext_en5(ext_en5), .ext_en6(ext_en6),
        .sdo(sdo), .sdo_oe(sdo_oe), .chan_en(chan_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // nb bits, din bit nb-1 goes first; end_high leaves sclk high at select fall
    task automatic xfer(input int nb, input logic [15:0] din, input bit end_high,
                        output logic [15:0] dout, output bit oe_ok);
        dout  = '0;
        oe_ok = 1'b1;
        cs = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sdi = din[nb-1-i];
            repeat (8) @(negedge clk);
            dout[nb-1-i] = sdo;
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            if (!(end_high && i == nb - 1)) begin
                sclk = 1'b0;
                repeat (8) @(negedge clk);
            end
        end
        cs = 1'b0;
        repeat (20) @(negedge clk);
        sclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_fault(input logic [7:0] v);
        fault_in = v;
        @(negedge clk);
        fault_in = '0;
        @(negedge clk);
    endtask

    logic [15:0] d;
    bit          ok;
    logic [7:0]  cur_cmd;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R1 chan_en", {8'h0, chan_en}, 16'h0);
        chk("R1 sdo_oe", {15'h0, sdo_oe}, 16'h0);
        xfer(8, 16'h0000, 1'b0, d, ok);
        chk("R1 fault read", d, 16'h0000);
        chk("R2 oe during xfer", {15'h0, ok}, 16'h1);
        chk("R2 oe after xfer", {15'h0, sdo_oe}, 16'h0);

        // exhaustive command sweep with distinct fault patterns
        for (int v = 0; v < 256; v++) begin
            pulse_fault(8'(v) ^ 8'h5A);
            xfer(8, {8'h0, 8'(v)}, 1'b0, d, ok);
            chk("R3 snapshot", d, {8'h0, 8'(v) ^ 8'h5A});
            chk("R5 command", {8'h0, chan_en}, {8'h0, 8'(v)});
        end
        xfer(8, 16'h00C3, 1'b0, d, ok);
        chk("R5 faults cleared", d, 16'h0000);
        cur_cmd = 8'hC3;

        // chained 16-bit transfer: snapshot then delayed passthrough
        pulse_fault(8'h81);
        xfer(16, 16'hA55A, 1'b0, d, ok);
        chk("R4 passthrough", d, 16'h81A5);
        chk("R5 last byte commits", {8'h0, chan_en}, 16'h005A);
        cur_cmd = 8'h5A;

        // 9 bits: not a multiple of 8
        pulse_fault(8'h24);
        xfer(9, 16'h01FF, 1'b0, d, ok);
        chk("R6 odd count cmd", {8'h0, chan_en}, {8'h0, cur_cmd});
        // 8 bits but sclk high at select fall
        xfer(8, 16'h00FF, 1'b1, d, ok);
        chk("R6 fault kept after odd", d, 16'h0024);
        chk("R6 sclk high cmd", {8'h0, chan_en}, {8'h0, cur_cmd});
        xfer(8, 16'h0000, 1'b0, d, ok);
        chk("R6 fault kept after sclk high", d, 16'h0024);
        cur_cmd = 8'h00;

        // discrete enables on channels 5 and 6
        ext_en5 = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 ext5", {8'h0, chan_en}, 16'h0010);
        ext_en5 = 1'b0; ext_en6 = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 ext6", {8'h0, chan_en}, 16'h0020);
        ext_en6 = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 ext off", {8'h0, chan_en}, 16'h0000);

        // short select pulse is ignored
        pulse_fault(8'h42);
        ok = 1'b1;
        cs = 1'b1;
        repeat (5) @(negedge clk);
        cs = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (sdo_oe !== 1'b0) ok = 1'b0;
        end
        chk("R8 glitch no oe", {15'h0, ok}, 16'h1);
        xfer(8, 16'h0000, 1'b0, d, ok);
        chk("R8 glitch faults kept", d, 16'h0042);

        // set and clear in the same cycle: set wins
        fault_in = 8'h04;
        xfer(8, 16'h0000, 1'b0, d, ok);
        fault_in = '0;
        @(negedge clk);
        xfer(8, 16'h0000, 1'b0, d, ok);
        chk("R9 set beats clear", d, 16'h0004);
        xfer(8, 16'h0000, 1'b0, d, ok);
        chk("R9 cleared later", d, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule